// File: doc/BRIEF.md
# Programmable Wait-State Bus Sequencer

This block sets how many bus-clock cycles each CPU bus access lasts. It uses the kind of area being reached and an 8-bit wait register that software programs. An access starts on a request, and the block holds the bus for a computed number of cycles. In the last of those cycles it raises a one-clock completion strobe. A new access may begin in that same final cycle, so transfers can run back to back with no idle gap.

The cycle count is not simply one plus the programmed wait count:

- A separate-bus write with no waits programmed still takes two cycles.
- A multiplexed bus never uses fewer than two waits.
- Special-function-register accesses have a fixed length.
- On-chip memory accesses have a fixed length chosen by a dedicated input.

The access length is fixed when the request is accepted. Later register writes, or changes to the bus-mode and memory-wait inputs, do not change an access that is already running.

The controller has two states:

- `ST_IDLE`: no access is running.
- `ST_XFER`: an access is running.

It has four transitions:

- start: `ST_IDLE` to `ST_XFER`, when a request arrives.
- step: `ST_XFER` to `ST_XFER`, counting cycles while the current cycle is not the last.
- chain: `ST_XFER` to `ST_XFER`, restarting at cycle 1 when a request is present in the last cycle.
- finish: `ST_XFER` to `ST_IDLE`, in the last cycle when no request is present.

Top module: `bus_wait_seq`

## Requirements
- R1: After reset the wait register is 8'hFF, so every external area takes 4 cycles. While idle, `cycle_cnt` is 0 and `done` and `wait_active` are 0.
- R2: A request is accepted only at a clock edge where the block is idle or in the last cycle of an access. A request held during any other cycle neither restarts nor lengthens the running access.
- R3: `req_area` codes 4, 5, 6 and 7 select external areas 0 to 3. Each external area k uses wait-register bits [2k+1:2k].
- R4: With `bus_mux` = 0, an external field of 00 gives 1 cycle for a read and 2 cycles for a write. Fields 01, 10 and 11 give 2, 3 and 4 cycles for both directions.
- R5: With `bus_mux` = 1, external fields 00, 01 and 10 give 3 cycles and field 11 gives 4 cycles.
- R6: `req_area` code 1 (special-function registers) always takes 2 cycles, whatever the register, bus mode or direction. Codes 2 and 3 behave the same way.
- R7: `req_area` code 0 (on-chip memory) takes 1 cycle when `imem_wait` = 0 and 2 cycles when it is 1.
- R8: `done` is high for exactly the last cycle of each access. If `req` is high in that cycle, the next access begins with cycle 1 on the following cycle.
- R9: During an access, `cycle_cnt` counts 1, 2, up to the length. `wait_active` is high in every access cycle except the last.
- R10: A wait-register write applies only to accesses accepted after the write edge. This holds for a write made during an access and for a write on the same edge as the acceptance.
- R11: `bus_mux` and `imem_wait` are taken at acceptance. Changing them during an access leaves its length unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Wait-register write enable |
| cfg_wdata | input | 8 | Wait-register write data |
| bus_mux | input | 1 | 1 = multiplexed bus, 0 = separate bus |
| imem_wait | input | 1 | On-chip memory wait select |
| req | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_area | input | 3 | Target area code |
| done | output | 1 | High in the last cycle of an access |
| cycle_cnt | output | 3 | Current access cycle, 0 when idle |
| wait_active | output | 1 | Access is being extended (not the last cycle) |

## Verification
The assertions assume that `req` and the other inputs change only between clock edges and hold steady across each edge. They also assume reset is held for at least one edge before any request. The bench drives every input on the falling clock edge and releases reset before its first request. It keeps the request and its qualifiers stable through the accepting edge, then drops the request, except in the back-to-back scenario, where holding it high is the stimulus being tested.

// File: rtl/bwseq_pkg.sv
package bwseq_pkg;
    typedef enum logic {
        ST_IDLE,
        ST_XFER
    } state_e;
endpackage

// File: rtl/bwseq_waitreg.sv
module bwseq_waitreg #(
    parameter int FIELD_W = 2,
    parameter int AREAS   = 4,
    localparam int REG_W  = FIELD_W * AREAS
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [REG_W-1:0]              wdata,
    output logic [AREAS-1:0][FIELD_W-1:0] fields
);
    logic [REG_W-1:0] reg_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_q <= '1;
        else if (we)
            reg_q <= wdata;
    end

    for (genvar k = 0; k < AREAS; k++) begin : g_field
        assign fields[k] = reg_q[k*FIELD_W +: FIELD_W];
    end
endmodule

// File: rtl/bwseq_len_calc.sv
module bwseq_len_calc #(
    parameter int FIELD_W = 2,
    parameter int AREAS   = 4,
    parameter int AREA_W  = 3,
    parameter int CNT_W   = 3
) (
    input  logic [AREA_W-1:0]             area,
    input  logic                          is_write,
    input  logic                          mux_mode,
    input  logic                          imem_wait,
    input  logic [AREAS-1:0][FIELD_W-1:0] fields,
    output logic [CNT_W-1:0]              len
);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO   = CNT_W'(2);
    localparam logic [CNT_W-1:0] THREE = CNT_W'(3);

    logic [FIELD_W-1:0] field;
    logic [CNT_W-1:0]   field_len;

    assign field     = fields[area[AREA_W-2:0]];
    assign field_len = CNT_W'(field) + ONE;

    always_comb begin
        if (area[AREA_W-1]) begin
            if (mux_mode)
                len = (field < FIELD_W'(2)) ? THREE : field_len;
            else if (field == '0)
                len = is_write ? TWO : ONE;
            else
                len = field_len;
        end else if (area == '0) begin
            len = imem_wait ? TWO : ONE;
        end else begin
            len = TWO;
        end
    end
endmodule

// File: rtl/bwseq_fsm.sv
module bwseq_fsm
    import bwseq_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [CNT_W-1:0] len_in,
    output logic             done,
    output logic [CNT_W-1:0] cycle_cnt,
    output logic             wait_active
);
    state_e           state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len_q;
    logic             last;
    logic             accept;

    assign last   = (state_q == ST_XFER) && (cnt_q == len_q);
    assign accept = req && ((state_q == ST_IDLE) || last);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            len_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q <= ST_XFER;
                        cnt_q   <= CNT_W'(1);
                        len_q   <= len_in;
                    end
                end
                ST_XFER: begin
                    if (accept) begin
                        cnt_q <= CNT_W'(1);
                        len_q <= len_in;
                    end else if (last) begin
                        state_q <= ST_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        done        = 1'b0;
        wait_active = 1'b0;
        cycle_cnt   = cnt_q;
        unique case (state_q)
            ST_IDLE: cycle_cnt = '0;
            ST_XFER: begin
                done        = last;
                wait_active = !last;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bus_wait_seq.sv
module bus_wait_seq #(
    parameter int  FIELD_W   = 2,
    parameter int  EXT_AREAS = 4,
    localparam int REG_W     = FIELD_W * EXT_AREAS,
    localparam int AREA_W    = $clog2(EXT_AREAS) + 1,
    localparam int LEN_MAX   = 1 << FIELD_W,
    localparam int CNT_W     = $clog2(LEN_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              bus_mux,
    input  logic              imem_wait,
    input  logic              req,
    input  logic              req_write,
    input  logic [AREA_W-1:0] req_area,
    output logic              done,
    output logic [CNT_W-1:0]  cycle_cnt,
    output logic              wait_active
);
    logic [EXT_AREAS-1:0][FIELD_W-1:0] fields;
    logic [CNT_W-1:0]                  len;

    bwseq_waitreg #(.FIELD_W(FIELD_W), .AREAS(EXT_AREAS)) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .wdata  (cfg_wdata),
        .fields (fields)
    );

    bwseq_len_calc #(
        .FIELD_W (FIELD_W),
        .AREAS   (EXT_AREAS),
        .AREA_W  (AREA_W),
        .CNT_W   (CNT_W)
    ) u_len (
        .area      (req_area),
        .is_write  (req_write),
        .mux_mode  (bus_mux),
        .imem_wait (imem_wait),
        .fields    (fields),
        .len       (len)
    );

    bwseq_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .len_in      (len),
        .done        (done),
        .cycle_cnt   (cycle_cnt),
        .wait_active (wait_active)
    );
endmodule

// File: rtl/bwseq_checker.sv
module bwseq_checker #(
    parameter int CNT_W   = 3,
    parameter int LEN_MAX = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req,
    input logic             done,
    input logic [CNT_W-1:0] cycle_cnt,
    input logic             wait_active
);
    a_r2_accept_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        (req && (cycle_cnt == '0 || done)) |=> (cycle_cnt == CNT_W'(1)));

    a_r2_no_restart_midway: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_cnt != '0 && !done) |=> (cycle_cnt == $past(cycle_cnt) + CNT_W'(1)));

    a_r8_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !req) |=> (cycle_cnt == '0 && !done));

    a_r8_done_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cycle_cnt != '0));

    a_r9_wait_not_last: assert property (@(posedge clk) disable iff (!rst_n)
        wait_active |-> (!done && cycle_cnt != '0));

    a_r9_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_cnt <= CNT_W'(LEN_MAX));
endmodule

bind bus_wait_seq bwseq_checker #(.CNT_W(CNT_W), .LEN_MAX(LEN_MAX)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .done        (done),
    .cycle_cnt   (cycle_cnt),
    .wait_active (wait_active)
);

// File: tb/bus_wait_seq_test.sv
module bus_wait_seq_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       bus_mux = 1'b0;
    logic       imem_wait = 1'b0;
    logic       req = 1'b0;
    logic       req_write = 1'b0;
    logic [2:0] req_area = '0;
    logic       done;
    logic [2:0] cycle_cnt;
    logic       wait_active;

    int compared = 0;
    int mismatched = 0;
    logic [7:0] cfg_model = 8'hFF;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_wait_seq uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .bus_mux(bus_mux), .imem_wait(imem_wait), .req(req),
        .req_write(req_write), .req_area(req_area), .done(done),
        .cycle_cnt(cycle_cnt), .wait_active(wait_active)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    function automatic int ref_len(input int area, input bit wr, input bit mux,
                                   input bit imw, input logic [7:0] r);
        int f;
        if (area == 0) return imw ? 2 : 1;
        if (area < 4) return 2;
        f = int'(r[2*(area-4) +: 2]);
        if (mux) return (f < 2) ? 3 : f + 1;
        if (f == 0) return wr ? 2 : 1;
        return f + 1;
    endfunction

    task automatic wr_cfg(input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        cfg_model = d;
    endtask

    // One access; optional write on the accepting edge, optional write/mux flip mid-access
    task automatic run_access(input int area, input bit wr, input int exp, input string rq,
                              input bit pre_we, input logic [7:0] pre_data,
                              input int mid_cycle, input logic [7:0] mid_data,
                              input bit mid_flip);
        int n;
        @(negedge clk);
        req_area = 3'(area);
        req_write = wr;
        req = 1'b1;
        if (pre_we) begin
            cfg_we = 1'b1;
            cfg_wdata = pre_data;
        end
        @(negedge clk);
        req = 1'b0;
        if (pre_we) begin
            cfg_we = 1'b0;
            cfg_model = pre_data;
        end
        n = 0;
        for (int i = 0; i < 8; i++) begin
            n++;
            cfg_we = 1'b0;
            chk(cycle_cnt == 3'(n), rq, "cycle_cnt", int'(cycle_cnt), n);
            chk(wait_active == (n < exp), "R9", "wait_active", int'(wait_active), int'(n < exp));
            if (n == mid_cycle) begin
                if (mid_flip) begin
                    bus_mux = ~bus_mux;
                    imem_wait = ~imem_wait;
                end else begin
                    cfg_we = 1'b1;
                    cfg_wdata = mid_data;
                    cfg_model = mid_data;
                end
            end
            if (done) break;
            @(negedge clk);
        end
        chk(n == exp, rq, "access length", n, exp);
        if (cfg_we) begin
            @(negedge clk);
            cfg_we = 1'b0;
        end
    endtask

    task automatic simple(input int area, input bit wr, input string rq);
        run_access(area, wr, ref_len(area, wr, bus_mux, imem_wait, cfg_model), rq,
                   1'b0, 8'h00, 0, 8'h00, 1'b0);
    endtask

    task automatic t_reset;
        chk(cycle_cnt == 0, "R1", "idle cycle_cnt", int'(cycle_cnt), 0);
        chk(done == 0, "R1", "idle done", int'(done), 0);
        chk(wait_active == 0, "R1", "idle wait_active", int'(wait_active), 0);
        for (int a = 4; a < 8; a++)
            run_access(a, 1'b0, 4, "R1", 1'b0, 8'h00, 0, 8'h00, 1'b0);
    endtask

    task automatic t_fields;
        bus_mux = 1'b0;
        wr_cfg(8'hE4); // area3=11 area2=10 area1=01 area0=00
        run_access(4, 1'b0, 1, "R3", 1'b0, 8'h00, 0, 8'h00, 1'b0);
        run_access(5, 1'b0, 2, "R3", 1'b0, 8'h00, 0, 8'h00, 1'b0);
        run_access(6, 1'b0, 3, "R3", 1'b0, 8'h00, 0, 8'h00, 1'b0);
        run_access(7, 1'b0, 4, "R3", 1'b0, 8'h00, 0, 8'h00, 1'b0);
    endtask

    task automatic t_sweep(input bit mux, input string rq);
        bus_mux = mux;
        for (int f = 0; f < 4; f++) begin
            wr_cfg({4{2'(f)}});
            for (int w = 0; w < 2; w++)
                for (int a = 4; a < 8; a++)
                    simple(a, w[0], rq);
        end
    endtask

    task automatic t_sfr;
        for (int m = 0; m < 2; m++) begin
            bus_mux = m[0];
            wr_cfg(m[0] ? 8'hFF : 8'h00);
            for (int a = 1; a < 4; a++)
                for (int w = 0; w < 2; w++)
                    run_access(a, w[0], 2, "R6", 1'b0, 8'h00, 0, 8'h00, 1'b0);
        end
    endtask

    task automatic t_imem;
        for (int i = 0; i < 8; i++) begin
            imem_wait = i[0];
            bus_mux = i[1];
            run_access(0, i[2], i[0] ? 2 : 1, "R7", 1'b0, 8'h00, 0, 8'h00, 1'b0);
        end
        imem_wait = 1'b0;
        bus_mux = 1'b0;
    endtask

    task automatic t_back2back;
        bus_mux = 1'b0;
        imem_wait = 1'b0;
        @(negedge clk);
        req_area = 3'd1;
        req = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(cycle_cnt == 3'((i % 2) + 1), "R2", "chained cycle_cnt", int'(cycle_cnt), (i % 2) + 1);
            chk(done == (i % 2 == 1), "R8", "chained done", int'(done), int'(i % 2 == 1));
        end
        req_area = 3'd0;
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            chk(done == 1 && cycle_cnt == 1, "R8", "single-cycle chain", int'(cycle_cnt), 1);
            @(negedge clk);
        end
        req = 1'b0;
        @(negedge clk);
        chk(cycle_cnt == 0 && done == 0, "R8", "release to idle", int'(cycle_cnt), 0);
    endtask

    task automatic t_late_write;
        bus_mux = 1'b0;
        wr_cfg(8'hFF);
        run_access(4, 1'b0, 4, "R10", 1'b0, 8'h00, 2, 8'h00, 1'b0);
        run_access(4, 1'b0, 1, "R10", 1'b0, 8'h00, 0, 8'h00, 1'b0);
        run_access(4, 1'b0, 1, "R10", 1'b1, 8'hFF, 0, 8'h00, 1'b0);
        run_access(4, 1'b0, 4, "R10", 1'b0, 8'h00, 0, 8'h00, 1'b0);
    endtask

    task automatic t_sample;
        bus_mux = 1'b0;
        imem_wait = 1'b0;
        wr_cfg(8'h55);
        run_access(4, 1'b1, 2, "R11", 1'b0, 8'h00, 1, 8'h00, 1'b1);
        run_access(4, 1'b1, 3, "R11", 1'b0, 8'h00, 0, 8'h00, 1'b0);
        run_access(0, 1'b0, 2, "R11", 1'b0, 8'h00, 1, 8'h00, 1'b1);
        bus_mux = 1'b0;
        imem_wait = 1'b0;
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fields();
        t_sweep(1'b0, "R4");
        t_sweep(1'b1, "R5");
        t_sfr();
        t_imem();
        t_back2back();
        t_late_write();
        t_sample();
        report();
    end
endmodule